// File: doc/BRIEF.md
# Debug Count and Breakpoint Register

This block is a 16-bit register owned by the debug controller. The same storage has three uses, chosen by a mode that is written together with the value.

- **Byte count.** It counts down the bytes left in a debugger register or memory transfer.
- **Cycle count.** It counts down once per CPU clock-enable, to time a stretch of execution.
- **Breakpoint.** It holds an address and asks the core to break when that address is fetched.

A host read always returns the bitwise complement of the stored value. A cycle count started from all ones therefore reads back as an up-count of elapsed cycles.

In idle mode the value is held untouched. A residual left by an earlier sequence, such as a CRC pass, stays readable. The breakpoint is one-shot. Any later counting command overwrites the address, so the host writes the breakpoint value last, just before resuming the core.

Top module: `dbg_count_brk`

## Requirements
- R1: After reset the stored value is 0, so `rd_data_o` reads 16'hFFFF, and `brk_o` and `cnt_done_o` are low. At all times `rd_data_o` is the bitwise complement of the stored value.
- R2: A cycle with `wr_en_i` high loads `wr_data_i` and `mode_i` at the clock edge. The mode codes are 2'b00 idle, 2'b01 byte count, 2'b10 cycle count and 2'b11 breakpoint. A write wins over any decrement in the same cycle.
- R3: In byte-count mode, each cycle with `byte_stb_i` high and a non-zero value lowers the value by one. The register never increments except by a write.
- R4: In byte-count mode, `cnt_done_o` is high for exactly the one cycle after the edge that takes the value from 1 to 0. Byte strobes while the value is 0 leave it at 0.
- R5: In cycle-count mode, each cycle with `cpu_ce_i` high lowers the value by one. After loading 16'hFFFF and N enabled cycles, `rd_data_o` reads N.
- R6: In cycle-count mode the value saturates at 0, so the readback stops at 16'hFFFF.
- R7: In idle mode, byte strobes and clock enables do not change the value, which keeps any residual.
- R8: In breakpoint mode, while armed, `brk_o` is high in the same cycle that `fetch_vld_i` is high and `pc_i` equals the stored value.
- R9: The break fires once and disarms. Only a new write re-arms it.
- R10: Outside breakpoint mode `brk_o` stays low even when the PC matches. In breakpoint mode, strobes and enables leave the stored address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 16 | Value to load |
| mode_i | input | 2 | Mode loaded with the write |
| rd_data_o | output | 16 | Inverted readback of the stored value |
| byte_stb_i | input | 1 | One byte transferred |
| cpu_ce_i | input | 1 | CPU clock enable |
| pc_i | input | 16 | Address being fetched |
| fetch_vld_i | input | 1 | `pc_i` is valid this cycle |
| brk_o | output | 1 | Break request pulse |
| cnt_done_o | output | 1 | Byte count reached zero |

## Verification
Writes and decrements show on `rd_data_o` in the cycle after the edge that samples them. `cnt_done_o` is registered and rises in that same following cycle. `brk_o` is combinational and due in the cycle in which the matching fetch is presented.

The bench keeps its own model of value, mode, arm flag and done flag, and updates it at each rising edge. Inputs are driven at the falling edge and outputs are compared one time unit later, so every comparison sees the state left by the previous edge plus the inputs of the current cycle.

// File: rtl/dbg_cnt_pkg.sv
package dbg_cnt_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_BYTES  = 2'b01,
    MODE_CYCLES = 2'b10,
    MODE_BREAK  = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/dbg_cnt_reg.sv
module dbg_cnt_reg
  import dbg_cnt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  cnt_mode_e    wr_mode_i,
  input  logic         byte_stb_i,
  input  logic         cpu_ce_i,
  output logic [W-1:0] cnt_o,
  output cnt_mode_e    mode_o,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  cnt_mode_e    mode_q;
  logic         done_q;
  logic         dec_req, dec;

  always_comb begin
    unique case (mode_q)
      MODE_BYTES:  dec_req = byte_stb_i;
      MODE_CYCLES: dec_req = cpu_ce_i;
      default:     dec_req = 1'b0;
    endcase
  end

  // saturate at zero in both counting modes
  assign dec = dec_req && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_IDLE;
      done_q <= 1'b0;
    end else if (wr_en_i) begin
      cnt_q  <= wr_data_i;
      mode_q <= wr_mode_i;
      done_q <= 1'b0;
    end else begin
      done_q <= dec && (mode_q == MODE_BYTES) && (cnt_q == ONE);
      if (dec) cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign done_o = done_q;

  // R3
  never_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> cnt_q <= $past(cnt_q));
  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  sat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_CYCLES && cnt_q == '0 && !wr_en_i) |=> cnt_q == '0);
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && !wr_en_i) |=> $stable(cnt_q));
  // R10
  brk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BREAK && !wr_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dbg_brk_cmp.sv
module dbg_brk_cmp
  import dbg_cnt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] pc_i,
  input  logic         fetch_vld_i,
  output logic         brk_o
);
  logic armed_q;
  logic hit;

  assign hit = armed_q && (mode_i == MODE_BREAK) && fetch_vld_i && (pc_i == cnt_i);

  // a write re-arms; first hit disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= 1'b1;
    else if (hit)     armed_q <= 1'b0;
  end

  assign brk_o = hit;

  // R9
  brk_oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && !wr_en_i) |=> !brk_o);
  // R10
  brk_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> mode_i == MODE_BREAK);
endmodule

// File: rtl/dbg_count_brk.sv
module dbg_count_brk
  import dbg_cnt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] rd_data_o,
  input  logic         byte_stb_i,
  input  logic         cpu_ce_i,
  input  logic [W-1:0] pc_i,
  input  logic         fetch_vld_i,
  output logic         brk_o,
  output logic         cnt_done_o
);
  logic [W-1:0] cnt;
  cnt_mode_e    mode;

  dbg_cnt_reg #(.W(W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .wr_mode_i  (cnt_mode_e'(mode_i)),
    .byte_stb_i (byte_stb_i),
    .cpu_ce_i   (cpu_ce_i),
    .cnt_o      (cnt),
    .mode_o     (mode),
    .done_o     (cnt_done_o)
  );

  dbg_brk_cmp #(.W(W)) u_brk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .mode_i      (mode),
    .cnt_i       (cnt),
    .pc_i        (pc_i),
    .fetch_vld_i (fetch_vld_i),
    .brk_o       (brk_o)
  );

  // readback is always inverted
  assign rd_data_o = ~cnt;

  // R4
  done_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_done_o |-> rd_data_o == '1);
  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == ~$past(wr_data_i));
endmodule

// File: tb/dbg_count_brk_test.sv
module dbg_count_brk_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] rd_data;
  logic        byte_stb = 1'b0;
  logic        cpu_ce = 1'b0;
  logic [15:0] pc = '0;
  logic        fetch_vld = 1'b0;
  logic        brk, done;

  int vectors = 0;
  int fails = 0;

  // model state
  logic [15:0] m_cnt = '0;
  int          m_mode = 0;
  bit          m_armed = 0;
  bit          m_done = 0;

  always #4 clk = ~clk;

  dbg_count_brk uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .mode_i(mode), .rd_data_o(rd_data), .byte_stb_i(byte_stb),
    .cpu_ce_i(cpu_ce), .pc_i(pc), .fetch_vld_i(fetch_vld),
    .brk_o(brk), .cnt_done_o(done)
  );

  function automatic bit exp_brk();
    return m_armed && m_mode == 3 && fetch_vld && pc == m_cnt;
  endfunction

  task automatic compare(input string tag);
    bit eb = exp_brk();
    vectors++;
    if (rd_data !== ~m_cnt) begin
      fails++; $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, ~m_cnt);
    end
    if (brk !== eb) begin
      fails++; $display("FAIL %s brk actual=%b expected=%b", tag, brk, eb);
    end
    if (done !== m_done) begin
      fails++; $display("FAIL %s done actual=%b expected=%b", tag, done, m_done);
    end
  endtask

  task automatic step(input string tag, input logic w, input logic [15:0] wd,
                      input logic [1:0] md, input logic bs, input logic ce,
                      input logic [15:0] p, input logic fv);
    bit hit;
    @(negedge clk);
    wr_en = w; wr_data = wd; mode = md; byte_stb = bs; cpu_ce = ce;
    pc = p; fetch_vld = fv;
    #1;
    compare(tag);
    hit = exp_brk();
    @(posedge clk);
    if (w) begin
      m_cnt = wd; m_mode = int'(md); m_armed = 1; m_done = 0;
    end else begin
      m_done = 0;
      if (m_mode == 1 && bs && m_cnt != 0) begin
        if (m_cnt == 1) m_done = 1;
        m_cnt = m_cnt - 1;
      end else if (m_mode == 2 && ce && m_cnt != 0) begin
        m_cnt = m_cnt - 1;
      end
      if (hit) m_armed = 0;
    end
  endtask

  task automatic idle(input string tag, input logic bs, input logic ce,
                      input logic [15:0] p, input logic fv);
    step(tag, 1'b0, 16'h0, 2'b00, bs, ce, p, fv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    compare("R1");
    rst_ni = 1'b1;
    idle("R1", 0, 0, 16'h0, 0);
    idle("R1", 1, 1, 16'h0, 1);

    // R2: write beats a same-cycle strobe; R3/R4 byte counting
    step("R2", 1, 16'h0003, 2'b01, 1, 0, 16'h0, 0);
    idle("R3", 1, 0, 16'h0, 0);
    idle("R3", 0, 0, 16'h0, 0);
    idle("R3", 1, 0, 16'h0, 0);
    idle("R4", 1, 0, 16'h0, 0);
    idle("R4", 1, 0, 16'h0, 0);
    idle("R4", 1, 0, 16'h0, 0);
    step("R2", 1, 16'h0005, 2'b01, 0, 0, 16'h0, 0);
    for (int i = 0; i < 8; i++) idle("R3", i[0], 1, 16'h0, 0);
    for (int i = 0; i < 4; i++) idle("R4", 1, 0, 16'h0, 0);

    // R7: idle holds a residual
    step("R2", 1, 16'h1234, 2'b00, 0, 0, 16'h0, 0);
    for (int i = 0; i < 4; i++) idle("R7", 1, 1, 16'h1234, 1);

    // R5: elapsed cycles read as an up-count
    step("R2", 1, 16'hFFFF, 2'b10, 0, 0, 16'h0, 0);
    for (int i = 0; i < 12; i++) idle("R5", 0, (i % 3) != 2, 16'h0, 0);
    @(negedge clk); #1;
    vectors++;
    if (rd_data !== 16'd8) begin
      fails++; $display("FAIL R5 elapsed actual=%0d expected=8", rd_data);
    end

    // R6: saturate
    step("R2", 1, 16'h0003, 2'b10, 0, 1, 16'h0, 0);
    for (int i = 0; i < 6; i++) idle("R6", 0, 1, 16'h0, 0);

    // R8/R9/R10 breakpoint
    step("R2", 1, 16'h0040, 2'b11, 0, 0, 16'h0, 0);
    idle("R8", 0, 0, 16'h003E, 1);
    idle("R8", 0, 0, 16'h0040, 0);
    idle("R10", 1, 1, 16'h003F, 1);
    idle("R8", 0, 0, 16'h0040, 1);
    idle("R9", 0, 0, 16'h0040, 1);
    idle("R9", 1, 1, 16'h0040, 1);
    step("R9", 1, 16'h0040, 2'b11, 0, 0, 16'h0, 0);
    idle("R9", 0, 0, 16'h0040, 1);
    idle("R9", 0, 0, 16'h0040, 1);
    step("R10", 1, 16'h0020, 2'b01, 0, 0, 16'h0, 0);
    idle("R10", 0, 0, 16'h0020, 1);
    step("R10", 1, 16'h0020, 2'b10, 0, 0, 16'h0, 0);
    idle("R10", 0, 0, 16'h0020, 1);
    idle("R10", 0, 0, 16'h001F, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule